// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Controller

This block holds the tags of a direct-mapped second-level cache whose lines are 16 bytes long and whose tag entries are one byte wide. A requester presents a physical byte address and a read or write flag. The block drops the in-line byte offset and splits the rest of the address into a line index and a tag. It reads the single entry that the index selects and reports a hit, a miss or a non-cacheable access. On a miss it asks for the line to be fetched and records the new tag in that entry. The data RAM, the memory bus and the line-fill datapath belong to other blocks. This block only issues the requests to them.

A parameter chooses the write policy. In write-through mode all eight bits of an entry hold address bits. The cacheable range is then 2^(4 + IDX_W + 8) bytes. In write-back mode the top bit of the entry is a dirty flag and only seven address bits are kept, so the range is half as large. Every entry also has a separate valid bit. A flush clears the valid bits by stepping through the indices, one per clock.

Top module: `l2tag_ctrl`

## Requirements
- R1: Address bits [3:0] take no part in the lookup. After a line has been filled, any address in the same 16-byte line hits.
- R2: Direct mapping. The index is bits [IDX_W+3:4]. A cacheable miss replaces the occupant of that index, so an access to the old line then misses.
- R3: A request is accepted when req_valid and req_ready are both high. resp_valid, resp_hit and resp_nc appear on the next cycle, and req_ready stays low until the block is idle again.
- R4: An address with any bit set at or above bit 4+IDX_W+TAG_BITS is non-cacheable, where TAG_BITS is 8 in write-through mode and 7 in write-back mode. It gives resp_nc=1 and resp_hit=0, issues no fill and allocates nothing.
- R5: Write-through mode compares eight tag bits and write-back mode compares seven. An address whose top set bit is 4+IDX_W+7 is therefore cacheable in write-through mode and non-cacheable in write-back mode.
- R6: In write-back mode, entry bit 7 is the dirty flag. A write hit sets it. A later miss on that valid dirty entry raises wb_req in the response cycle, with wb_line_addr = {old tag, index, 4'b0}. fill_req follows one cycle later.
- R7: In write-through mode, wb_req never rises and the dirty flag is never set. Every cacheable write, hit or miss, raises wt_fwd in the response cycle. A write hit leaves the entry unchanged, so the line keeps hitting.
- R8: A miss on a clean or invalid entry gives no wb_req. fill_req rises for one cycle, two cycles after acceptance, with fill_line_addr equal to the request address with bits [3:0] cleared. The entry then holds the new tag and is valid.
- R9: flush_req taken while idle holds flush_busy high for exactly 2^IDX_W cycles. req_ready is low during that time, and afterwards every access misses.
- R10: After reset every entry is invalid and req_ready is high.
- R11: In write-back mode a write miss allocates the line already dirty, so evicting it later raises wb_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address |
| req_ready | output | 1 | Block is idle and can accept a request |
| resp_valid | output | 1 | Lookup result valid this cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_nc | output | 1 | Address above cacheable range, bypass |
| wt_fwd | output | 1 | Forward cacheable write to memory (write-through) |
| wb_req | output | 1 | Write back the dirty victim line |
| wb_line_addr | output | ADDR_W | Line address of the victim |
| fill_req | output | 1 | Fetch the missed line |
| fill_line_addr | output | ADDR_W | Line address to fetch |
| flush_req | input | 1 | Start invalidating all entries |
| flush_busy | output | 1 | Invalidation in progress |

## Verification
On every cycle the assertions check the following. A response appears only after an accepted request. A non-cacheable response never reports a hit and is never followed by a fill. A hit issues no fill. A write-back request is always followed by a fill, and it never occurs in write-through mode. A flush blocks new requests. Only the bench's scenarios, checked against its own tag model for both policies, can show whether the contents are right: offset-blind hits, eviction of a colliding line, the dirty flag surviving until eviction, the halved range in write-back mode, the victim address that is reported, and the length and effect of a flush.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
  localparam int ENTRY_W = 8;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef enum logic [1:0] {PH_IDLE, PH_RESP, PH_FILL} phase_e;

  // With write-back, entry bit 7 carries the dirty flag.
  function automatic entry_t entry_pack(logic wb, logic dirty, entry_t tag);
    return wb ? {dirty, tag[ENTRY_W-2:0]} : tag;
  endfunction

  function automatic logic entry_is_dirty(logic wb, entry_t e);
    return wb & e[ENTRY_W-1];
  endfunction

  function automatic entry_t entry_tag(logic wb, entry_t e);
    return wb ? {1'b0, e[ENTRY_W-2:0]} : e;
  endfunction
endpackage

// File: rtl/l2tag_addr_dec.sv
module l2tag_addr_dec
  import l2tag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 4,
  parameter int IDX_W    = 8,
  parameter int TAG_BITS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output entry_t            tag,
  output logic              cacheable
);
  localparam int TAG_LO  = OFF_W + IDX_W;
  localparam int RANGE_W = TAG_LO + TAG_BITS;

  logic unused_off;
  assign unused_off = ^addr[OFF_W-1:0];

  assign idx = addr[TAG_LO-1:OFF_W];

  always_comb begin
    tag = '0;
    tag[TAG_BITS-1:0] = addr[RANGE_W-1:TAG_LO];
  end

  generate
    if (RANGE_W < ADDR_W) begin : g_range
      assign cacheable = (addr[ADDR_W-1:RANGE_W] == '0);
    end else begin : g_full
      assign cacheable = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/l2tag_store.sv
module l2tag_store
  import l2tag_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output entry_t           rd_entry,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] vld;

  assign rd_entry = mem[rd_idx];
  assign rd_valid = vld[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (wr_en)  vld[wr_idx]  <= 1'b1;
      if (inv_en) vld[inv_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/l2tag_sweep.sv
module l2tag_sweep #(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end
endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
  import l2tag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_nc,
  output logic              wt_fwd,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_line_addr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_line_addr,
  input  logic              flush_req,
  output logic              flush_busy
);
  localparam int OFF_W    = 4;
  localparam int TAG_BITS = WRITE_BACK ? ENTRY_W - 1 : ENTRY_W;
  localparam int TAG_LO   = OFF_W + IDX_W;

  function automatic logic [ADDR_W-1:0] make_line(entry_t t, logic [IDX_W-1:0] i);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(t) << TAG_LO;
    a = a | (ADDR_W'(i) << OFF_W);
    return a;
  endfunction

  phase_e phase;

  logic [IDX_W-1:0] dec_idx;
  entry_t           dec_tag;
  logic             dec_cacheable;
  entry_t           rd_entry;
  logic             rd_valid;
  logic             wr_en;
  entry_t           wr_entry;
  logic             sweep_busy;
  logic [IDX_W-1:0] sweep_idx;

  // Named internal events
  logic accept;
  logic flush_take;
  logic lookup_hit;
  logic victim_dirty;

  logic             r_write, r_nc, r_hit, r_vic_valid, r_vic_dirty;
  logic [IDX_W-1:0] r_idx;
  entry_t           r_tag, r_vic_tag;

  l2tag_addr_dec #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_BITS(TAG_BITS)
  ) u_dec (
    .addr(req_addr), .idx(dec_idx), .tag(dec_tag), .cacheable(dec_cacheable)
  );

  l2tag_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(dec_idx), .rd_entry(rd_entry), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_idx(r_idx), .wr_entry(wr_entry),
    .inv_en(sweep_busy), .inv_idx(sweep_idx)
  );

  l2tag_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(flush_take),
    .busy(sweep_busy), .idx(sweep_idx)
  );

  assign flush_take   = flush_req && (phase == PH_IDLE) && !sweep_busy;
  assign req_ready    = (phase == PH_IDLE) && !sweep_busy && !flush_req;
  assign accept       = req_valid && req_ready;
  assign lookup_hit   = dec_cacheable && rd_valid &&
                        (entry_tag(WRITE_BACK, rd_entry) == dec_tag);
  assign victim_dirty = entry_is_dirty(WRITE_BACK, rd_entry);
  assign flush_busy   = sweep_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      r_write     <= 1'b0;
      r_nc        <= 1'b0;
      r_hit       <= 1'b0;
      r_vic_valid <= 1'b0;
      r_vic_dirty <= 1'b0;
      r_idx       <= '0;
      r_tag       <= '0;
      r_vic_tag   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase       <= PH_RESP;
          r_write     <= req_write;
          r_nc        <= !dec_cacheable;
          r_hit       <= lookup_hit;
          r_vic_valid <= rd_valid;
          r_vic_dirty <= victim_dirty;
          r_idx       <= dec_idx;
          r_tag       <= dec_tag;
          r_vic_tag   <= entry_tag(WRITE_BACK, rd_entry);
        end
        PH_RESP: phase <= (!r_nc && !r_hit) ? PH_FILL : PH_IDLE;
        PH_FILL: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    resp_valid     = (phase == PH_RESP);
    resp_hit       = resp_valid && r_hit;
    resp_nc        = resp_valid && r_nc;
    wt_fwd         = resp_valid && !WRITE_BACK && r_write && !r_nc;
    wb_req         = resp_valid && WRITE_BACK && !r_nc && !r_hit &&
                     r_vic_valid && r_vic_dirty;
    wb_line_addr   = make_line(r_vic_tag, r_idx);
    fill_req       = (phase == PH_FILL);
    fill_line_addr = make_line(r_tag, r_idx);
    wr_en          = 1'b0;
    wr_entry       = entry_pack(WRITE_BACK, 1'b0, r_tag);
    if (resp_valid && WRITE_BACK && r_hit && r_write) begin
      wr_en    = 1'b1;
      wr_entry = entry_pack(WRITE_BACK, 1'b1, r_tag);
    end else if (fill_req) begin
      wr_en    = 1'b1;
      wr_entry = entry_pack(WRITE_BACK, WRITE_BACK && r_write, r_tag);
    end
  end
endmodule

// File: rtl/l2tag_chk.sv
module l2tag_chk #(
  parameter bit WRITE_BACK = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_nc,
  input logic wb_req,
  input logic fill_req,
  input logic flush_busy
);
  // R3
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));
  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || fill_req) |-> !req_ready);
  // R4
  nc_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_nc) |-> (!resp_hit && !wb_req));
  // R4
  nc_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_nc) |=> !fill_req);
  // R2
  hit_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |=> !fill_req);
  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> fill_req);
  // R7
  wt_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> !wb_req);
  // R9
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> (!req_ready && !resp_valid && !fill_req));
endmodule

bind l2tag_ctrl l2tag_chk #(.WRITE_BACK(WRITE_BACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_nc(resp_nc),
  .wb_req(wb_req), .fill_req(fill_req), .flush_busy(flush_busy)
);

// File: tb/tb_l2tag_ctrl.sv
module tb_l2tag_ctrl;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int NE = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, flush_req = 1'b0;
  logic [AW-1:0] req_addr = '0;

  // index 1 = write-back instance, index 0 = write-through instance
  logic [1:0] rdy, rv, hit, nc, fwd, wbr, fil, fb;
  logic [AW-1:0] wba [2];
  logic [AW-1:0] fla [2];

  int checks = 0, errors = 0;
  bit done = 0;

  logic       mv [2][NE];
  logic [7:0] mt [2][NE];
  logic       md [2][NE];

  always #5 clk = ~clk;

  l2tag_ctrl #(.ADDR_W(AW), .IDX_W(IW), .WRITE_BACK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(rdy[1]), .resp_valid(rv[1]),
    .resp_hit(hit[1]), .resp_nc(nc[1]), .wt_fwd(fwd[1]), .wb_req(wbr[1]),
    .wb_line_addr(wba[1]), .fill_req(fil[1]), .fill_line_addr(fla[1]),
    .flush_req(flush_req), .flush_busy(fb[1]));

  l2tag_ctrl #(.ADDR_W(AW), .IDX_W(IW), .WRITE_BACK(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(rdy[0]), .resp_valid(rv[0]),
    .resp_hit(hit[0]), .resp_nc(nc[0]), .wt_fwd(fwd[0]), .wb_req(wbr[0]),
    .wb_line_addr(wba[0]), .fill_req(fil[0]), .fill_line_addr(fla[0]),
    .flush_req(flush_req), .flush_busy(fb[0]));

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int tbits(int m);
    return (m == 1) ? 7 : 8;
  endfunction

  function automatic bit in_range(int m, logic [AW-1:0] a);
    return (a >> (4 + IW + tbits(m))) == 0;
  endfunction

  function automatic logic [7:0] tag_of(int m, logic [AW-1:0] a);
    return 8'((a >> (4 + IW)) & ((1 << tbits(m)) - 1));
  endfunction

  task automatic access(input logic w, input logic [AW-1:0] a, input string lbl);
    bit e_nc[2], e_hit[2], e_wb[2], e_fill[2];
    logic [AW-1:0] e_wba[2];
    int ix;
    ix = int'(a[4 +: IW]);
    @(negedge clk);
    chk(lbl, "ready idle", AW'(rdy), AW'(2'b11));
    req_valid = 1'b1; req_write = w; req_addr = a;
    for (int m = 0; m < 2; m++) begin
      e_nc[m]   = !in_range(m, a);
      e_hit[m]  = !e_nc[m] && mv[m][ix] && (mt[m][ix] == tag_of(m, a));
      e_wb[m]   = (m == 1) && !e_nc[m] && !e_hit[m] && mv[m][ix] && md[m][ix];
      e_wba[m]  = (AW'(mt[m][ix]) << (4 + IW)) | (AW'(ix) << 4);
      e_fill[m] = !e_nc[m] && !e_hit[m];
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int m = 0; m < 2; m++) begin
      chk(lbl, "resp_valid", AW'(rv[m]), 1);
      chk(lbl, "ready busy", AW'(rdy[m]), 0);
      chk(lbl, "hit", AW'(hit[m]), AW'(e_hit[m]));
      chk(lbl, "nc", AW'(nc[m]), AW'(e_nc[m]));
      chk(lbl, "wb_req", AW'(wbr[m]), AW'(e_wb[m]));
      if (e_wb[m]) chk(lbl, "wb addr", wba[m], e_wba[m]);
      chk(lbl, "wt_fwd", AW'(fwd[m]), AW'((m == 0) && w && !e_nc[m]));
      if (e_hit[m] && w && m == 1) md[m][ix] = 1'b1;
      if (e_fill[m]) begin
        mv[m][ix] = 1'b1; mt[m][ix] = tag_of(m, a); md[m][ix] = (m == 1) && w;
      end
    end
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(lbl, "fill_req", AW'(fil[m]), AW'(e_fill[m]));
      if (e_fill[m]) chk(lbl, "fill addr", fla[m], a & ~AW'(15));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    int n;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < NE; i++) begin mv[m][i] = 0; mt[m][i] = 0; md[m][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "ready", AW'(rdy), AW'(2'b11));
    chk("R10", "resp_valid", AW'(rv), 0);
    chk("R10", "flush_busy", AW'(fb), 0);
    access(1'b0, 32'h0000_0120, "R10");  // first access misses
    access(1'b0, 32'h0000_012F, "R1");   // same line, other offset
    access(1'b0, 32'h0000_0121, "R3");
    access(1'b1, 32'h0000_0125, "R6");   // write hit: dirty in WB, fwd in WT
    access(1'b0, 32'h0000_0125, "R7");   // WT line still hits
    access(1'b0, 32'h0000_0320, "R6");   // evict dirty: wb 0x120 then fill
    access(1'b0, 32'h0000_0120, "R2");   // old line evicted
    access(1'b0, 32'h0000_0230, "R8");   // clean miss
    access(1'b1, 32'h0000_0340, "R7");   // WT write miss forwards
    access(1'b1, 32'h0000_0450, "R11");  // WB write miss allocates dirty
    access(1'b0, 32'h0000_0550, "R11");  // evicting it writes back 0x450
    access(1'b0, 32'h0000_8060, "R5");   // WT cacheable, WB beyond range
    access(1'b0, 32'h0000_8064, "R5");
    access(1'b1, 32'h0001_0070, "R4");   // non-cacheable for both
    access(1'b0, 32'h0001_0070, "R4");
    access(1'b0, 32'h0000_0070, "R4");   // nothing was allocated
    n = $urandom(32'd1234);
    for (int k = 0; k < 400; k++) begin
      a = AW'((($urandom % 4) << 8) | (($urandom % NE) << 4) | ($urandom % 16));
      if ($urandom % 8 == 0) a[15] = 1'b1;
      if ($urandom % 16 == 0) a[16 + ($urandom % 8)] = 1'b1;
      access(1'($urandom % 2), a, "R2");
    end
    // R9 flush
    @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    n = 0;
    while (fb != 2'b00 && n < 100) begin
      chk("R9", "ready during flush", AW'(rdy), 0);
      n++;
      @(negedge clk);
    end
    chk("R9", "busy cycles", AW'(n), AW'(NE));
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < NE; i++) mv[m][i] = 0;
    for (int i = 0; i < NE; i++) access(1'b0, AW'(i << 4), "R9");
    finish_run();
  end
endmodule